// File: doc/BRIEF.md
# Power-Sourcing Port Mode Controller

This block is the control state machine for one port of a power-sourcing controller on a twisted-pair network link. It decides when the port asks the analog engines for a signature detection or a class measurement. It decides when the port's power switch is closed and why it was last opened. In autonomous operation it also picks the current-cut and current-limit thresholds from the measured class.

A 2-bit host field selects the operating style. Three straps are captured only while reset is active: an autonomous-enable strap, a midspan strap and a 2-bit power-budget strap. The analog engines are represented by request/done handshakes. A request stays high until the engine answers with a one-cycle done pulse and its result. Host commands are one-cycle pulses. Faults, disconnects and mode changes are level inputs that the controller sees on every clock.

Top module: `pse_port_ctrl`

## Requirements
- R1: The operating field decodes as 00 shutdown, 01 manual, 10 semi-auto and 11 autonomous. When the latched autonomous strap is low, code 11 is a reserved value and the port behaves exactly as in shutdown.
- R2: The autonomous strap, the midspan strap and the power-budget strap are captured on every clock edge where reset is active (`rst_n` low or `reset_all` high), and only then. Strap changes made after reset do not affect behaviour, and `midspan` shows the captured midspan value.
- R3: In shutdown, one cycle after the field is sampled, `det_req`, `cls_req` and `power_on` are all low. A port that was powered opens with `off_reason` = 3.
- R4: In manual mode, `cmd_detect` starts exactly one detection (`det_req` stays high until `det_done`), after which the port idles and `det_status` holds `det_valid`. `cmd_classify` does the same for one class measurement and stores `cls_result` in `class_status`. Neither measurement repeats on its own.
- R5: `cmd_power_on` closes the switch on the next edge from any unpowered state, subject to the mode. In manual mode it always does so. In semi-auto mode it does so only when `det_status` is 1. In shutdown and autonomous modes it is ignored. In manual idle it takes priority over `cmd_detect`, which takes priority over `cmd_classify`.
- R6: In semi-auto mode no detection runs while `det_en` is low. With `det_en` high, detection repeats, and a valid detection is followed by one class measurement when `cls_en` is high. The port never powers itself. `det_req`, `cls_req` and `power_on` are never high together.
- R7: In autonomous mode, detection repeats without any enable. A valid detection is always followed by classification. On `cls_done` with an admitted class, `power_on` rises on the next edge. An invalid detection returns to detection.
- R8: On an autonomous power-up, `icut_code`/`ilim_code` (mA) are loaded from the class: 0→375/425, 1→112/425, 2→206/425, 3→375/425, 4→638/850, 5→750/1000, 6→850/1000, 7→950/1023. No other event changes them apart from reset.
- R9: Classes 0–4 request budget tier 0, class 5 tier 1, class 6 tier 2 and class 7 tier 3. Budget strap 00 = 38.7 W, 01 = 52.7 W, 10 = 70 W, 11 = 90 W. A class whose tier exceeds the latched budget code is refused, and the port returns to detection unpowered.
- R10: `fault_ilim` while powered opens the switch on the next edge in every mode with `off_reason` = 1. It outranks every other power-off cause.
- R11: `disconnect` while powered opens the switch with `off_reason` = 2 when `dcon_en` is high. When `dcon_en` is low it has no effect.
- R12: `cmd_power_off`, or a change to shutdown, opens the switch with `off_reason` = 3. Every power-off clears `det_status`. After a power-off in autonomous mode, `det_req` rises two edges later.
- R13: Reset leaves `power_on`, `det_req`, `cls_req`, `det_status`, `class_status` and `off_reason` at 0, and leaves the thresholds at 375/425.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_all | input | 1 | Synchronous global reset from a host register bit |
| strap_auto | input | 1 | Autonomous-enable strap, captured during reset |
| strap_mid | input | 1 | Midspan strap, captured during reset |
| strap_pwr | input | 2 | Power-budget strap, captured during reset |
| opmode | input | 2 | Host operating-mode field |
| det_en | input | 1 | Host detection enable (semi-auto) |
| cls_en | input | 1 | Host classification enable (semi-auto) |
| dcon_en | input | 1 | Disconnect-detection enable |
| cmd_detect | input | 1 | Host pulse: one detection (manual) |
| cmd_classify | input | 1 | Host pulse: one classification (manual) |
| cmd_power_on | input | 1 | Host pulse: close the switch |
| cmd_power_off | input | 1 | Host pulse: open the switch |
| det_done | input | 1 | Detection engine finished |
| det_valid | input | 1 | Detection found a valid signature |
| cls_done | input | 1 | Class engine finished |
| cls_result | input | 3 | Measured class |
| fault_ilim | input | 1 | Current-limit fault |
| disconnect | input | 1 | Disconnect event |
| det_req | output | 1 | Detection request to the engine |
| cls_req | output | 1 | Classification request to the engine |
| power_on | output | 1 | Power switch command |
| det_status | output | 1 | Result of the last detection |
| class_status | output | 3 | Result of the last classification |
| off_reason | output | 2 | Last power-off cause: 0 none, 1 fault, 2 disconnect, 3 host/shutdown |
| icut_code | output | 10 | Cut current threshold in mA |
| ilim_code | output | 10 | Limit current threshold in mA |
| midspan | output | 1 | Captured midspan strap |

## Verification
A wrong state register shows up one edge later as a request or switch level that disagrees with the mode: a detection request in shutdown, two outputs high at once, or a powered port that ignores a fault. A corrupted status or threshold register stays visible on `det_status`, `class_status`, `off_reason` or the current codes until the next event that rewrites it. Comparing every output on every cycle therefore catches most faults within one or two clocks of the stimulus. A strap that is captured after reset only shows when a later class crosses the budget, or when a later reset-free run reaches code 11.

// File: rtl/pse_port_pkg.sv
package pse_port_pkg;

  localparam int CODE_W = 10;
  localparam int CLS_W  = 3;
  localparam int BUD_W  = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_MAN  = 2'b01,
    MODE_SEMI = 2'b10,
    MODE_AUTO = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DET  = 2'd1,
    ST_CLS  = 2'd2,
    ST_PWR  = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    WHY_NONE  = 2'd0,
    WHY_FAULT = 2'd1,
    WHY_DISC  = 2'd2,
    WHY_HOST  = 2'd3
  } why_e;

  // Reserved code 11 without the autonomous strap falls back to shutdown.
  function automatic mode_e mode_decode(input logic [1:0] field, input logic auto_strap);
    if (field == 2'b11 && !auto_strap) return MODE_OFF;
    return mode_e'(field);
  endfunction

  function automatic logic [CODE_W-1:0] cut_ma(input logic [CLS_W-1:0] c);
    case (c)
      3'd1:    return CODE_W'(112);
      3'd2:    return CODE_W'(206);
      3'd4:    return CODE_W'(638);
      3'd5:    return CODE_W'(750);
      3'd6:    return CODE_W'(850);
      3'd7:    return CODE_W'(950);
      default: return CODE_W'(375);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] lim_ma(input logic [CLS_W-1:0] c);
    case (c)
      3'd4:         return CODE_W'(850);
      3'd5, 3'd6:   return CODE_W'(1000);
      3'd7:         return CODE_W'(1023);
      default:      return CODE_W'(425);
    endcase
  endfunction

  // Budget tier a class asks for; standard classes fit the smallest budget.
  function automatic logic [BUD_W-1:0] tier_of(input logic [CLS_W-1:0] c);
    if (c < CLS_W'(5)) return '0;
    return BUD_W'(c - CLS_W'(4));
  endfunction

endpackage

// File: rtl/pse_strap_latch.sv
module pse_strap_latch #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          in_reset,
  input  logic          auto_pin,
  input  logic          mid_pin,
  input  logic [BW-1:0] bud_pin,
  output logic          auto_q,
  output logic          mid_q,
  output logic [BW-1:0] bud_q
);
  always_ff @(posedge clk) begin
    if (in_reset) begin
      auto_q <= auto_pin;
      mid_q  <= mid_pin;
      bud_q  <= bud_pin;
    end
  end
endmodule

// File: rtl/pse_class_policy.sv
module pse_class_policy
  import pse_port_pkg::*;
(
  input  logic [CLS_W-1:0]  cls,
  input  logic [BUD_W-1:0]  budget,
  output logic [CODE_W-1:0] cut,
  output logic [CODE_W-1:0] lim,
  output logic              admit
);
  always_comb begin
    cut   = cut_ma(cls);
    lim   = lim_ma(cls);
    admit = (tier_of(cls) <= budget);
  end
endmodule

// File: rtl/pse_port_fsm.sv
module pse_port_fsm
  import pse_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_all,
  input  mode_e             mode,
  input  logic              det_en,
  input  logic              cls_en,
  input  logic              dcon_en,
  input  logic              cmd_det,
  input  logic              cmd_cls,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              det_done,
  input  logic              det_valid,
  input  logic              cls_done,
  input  logic [CLS_W-1:0]  cls_result,
  input  logic              fault,
  input  logic              disc,
  input  logic [CODE_W-1:0] pol_cut,
  input  logic [CODE_W-1:0] pol_lim,
  input  logic              pol_admit,
  output state_e            st_q,
  output logic              det_ok_q,
  output logic [CLS_W-1:0]  cls_q,
  output why_e              why_q,
  output logic [CODE_W-1:0] cut_q,
  output logic [CODE_W-1:0] lim_q,
  output logic              pwr_up_evt,
  output logic              pwr_dn_evt
);
  state_e st_d;
  why_e   why_sel;
  logic   pon_ok;
  logic   host_on;
  logic   det_take;
  logic   cls_take;
  logic   auto_load;

  always_comb begin
    pon_ok  = (mode == MODE_MAN) || (mode == MODE_SEMI && det_ok_q);
    host_on = cmd_on && pon_ok;
    if (fault)                 why_sel = WHY_FAULT;
    else if (disc && dcon_en)  why_sel = WHY_DISC;
    else                       why_sel = WHY_HOST;
  end

  always_comb begin
    st_d = st_q;
    if (st_q == ST_PWR) begin
      if (mode == MODE_OFF || fault || (disc && dcon_en) || cmd_off) st_d = ST_IDLE;
    end else if (mode == MODE_OFF) begin
      st_d = ST_IDLE;
    end else if (host_on) begin
      st_d = ST_PWR;
    end else begin
      case (st_q)
        ST_IDLE: begin
          case (mode)
            MODE_MAN:  st_d = cmd_det ? ST_DET : (cmd_cls ? ST_CLS : ST_IDLE);
            MODE_SEMI: st_d = det_en ? ST_DET : ST_IDLE;
            default:   st_d = ST_DET;
          endcase
        end
        ST_DET: begin
          if (det_done) begin
            if (det_valid && (mode == MODE_AUTO || (mode == MODE_SEMI && cls_en))) st_d = ST_CLS;
            else st_d = ST_IDLE;
          end
        end
        ST_CLS: begin
          if (cls_done) st_d = (mode == MODE_AUTO && pol_admit) ? ST_PWR : ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign pwr_up_evt = (st_q != ST_PWR) && (st_d == ST_PWR);
  assign pwr_dn_evt = (st_q == ST_PWR) && (st_d != ST_PWR);
  assign auto_load  = pwr_up_evt && (mode == MODE_AUTO);
  assign det_take   = (st_q == ST_DET) && det_done && (mode != MODE_OFF) && !host_on;
  assign cls_take   = (st_q == ST_CLS) && cls_done && (mode != MODE_OFF) && !host_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      det_ok_q <= 1'b0;
      cls_q    <= '0;
      why_q    <= WHY_NONE;
      cut_q    <= cut_ma('0);
      lim_q    <= lim_ma('0);
    end else if (reset_all) begin
      st_q     <= ST_IDLE;
      det_ok_q <= 1'b0;
      cls_q    <= '0;
      why_q    <= WHY_NONE;
      cut_q    <= cut_ma('0);
      lim_q    <= lim_ma('0);
    end else begin
      st_q <= st_d;
      if (pwr_dn_evt) begin
        det_ok_q <= 1'b0;
        why_q    <= why_sel;
      end else if (det_take) begin
        det_ok_q <= det_valid;
      end
      if (cls_take) cls_q <= cls_result;
      if (auto_load) begin
        cut_q <= pol_cut;
        lim_q <= pol_lim;
      end
    end
  end
endmodule

// File: rtl/pse_port_ctrl.sv
module pse_port_ctrl
  import pse_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_all,
  input  logic              strap_auto,
  input  logic              strap_mid,
  input  logic [BUD_W-1:0]  strap_pwr,
  input  logic [1:0]        opmode,
  input  logic              det_en,
  input  logic              cls_en,
  input  logic              dcon_en,
  input  logic              cmd_detect,
  input  logic              cmd_classify,
  input  logic              cmd_power_on,
  input  logic              cmd_power_off,
  input  logic              det_done,
  input  logic              det_valid,
  input  logic              cls_done,
  input  logic [CLS_W-1:0]  cls_result,
  input  logic              fault_ilim,
  input  logic              disconnect,
  output logic              det_req,
  output logic              cls_req,
  output logic              power_on,
  output logic              det_status,
  output logic [CLS_W-1:0]  class_status,
  output logic [1:0]        off_reason,
  output logic [CODE_W-1:0] icut_code,
  output logic [CODE_W-1:0] ilim_code,
  output logic              midspan
);
  logic              in_reset;
  logic              auto_q;
  logic [BUD_W-1:0]  bud_q;
  mode_e             mode_eff;
  logic [CODE_W-1:0] pol_cut;
  logic [CODE_W-1:0] pol_lim;
  logic              pol_admit;
  state_e            st_q;
  why_e              why_q;
  logic              pwr_up_evt;
  logic              pwr_dn_evt;

  assign in_reset = !rst_n || reset_all;

  pse_strap_latch #(.BW(BUD_W)) u_straps (
    .clk      (clk),
    .in_reset (in_reset),
    .auto_pin (strap_auto),
    .mid_pin  (strap_mid),
    .bud_pin  (strap_pwr),
    .auto_q   (auto_q),
    .mid_q    (midspan),
    .bud_q    (bud_q)
  );

  assign mode_eff = mode_decode(opmode, auto_q);

  pse_class_policy u_policy (
    .cls    (cls_result),
    .budget (bud_q),
    .cut    (pol_cut),
    .lim    (pol_lim),
    .admit  (pol_admit)
  );

  pse_port_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_all  (reset_all),
    .mode       (mode_eff),
    .det_en     (det_en),
    .cls_en     (cls_en),
    .dcon_en    (dcon_en),
    .cmd_det    (cmd_detect),
    .cmd_cls    (cmd_classify),
    .cmd_on     (cmd_power_on),
    .cmd_off    (cmd_power_off),
    .det_done   (det_done),
    .det_valid  (det_valid),
    .cls_done   (cls_done),
    .cls_result (cls_result),
    .fault      (fault_ilim),
    .disc       (disconnect),
    .pol_cut    (pol_cut),
    .pol_lim    (pol_lim),
    .pol_admit  (pol_admit),
    .st_q       (st_q),
    .det_ok_q   (det_status),
    .cls_q      (class_status),
    .why_q      (why_q),
    .cut_q      (icut_code),
    .lim_q      (ilim_code),
    .pwr_up_evt (pwr_up_evt),
    .pwr_dn_evt (pwr_dn_evt)
  );

  assign det_req    = (st_q == ST_DET);
  assign cls_req    = (st_q == ST_CLS);
  assign power_on   = (st_q == ST_PWR);
  assign off_reason = why_q;
endmodule

// File: rtl/pse_port_ctrl_chk.sv
module pse_port_ctrl_chk (
  input logic       clk,
  input logic       in_reset,
  input logic [1:0] mode_eff,
  input logic       power_on,
  input logic       det_req,
  input logic       cls_req,
  input logic       fault_ilim,
  input logic       disconnect,
  input logic       dcon_en,
  input logic       cmd_power_on,
  input logic       cmd_power_off,
  input logic       cls_done,
  input logic       pol_admit,
  input logic       pwr_up_evt,
  input logic       auto_q,
  input logic [1:0] bud_q,
  input logic [1:0] off_reason
);
  p_shutdown_dark_r3: assert property (@(posedge clk) disable iff (in_reset)
    mode_eff == 2'b00 |=> !power_on && !det_req && !cls_req);

  p_fault_off_r10: assert property (@(posedge clk) disable iff (in_reset)
    power_on && fault_ilim |=> !power_on && off_reason == 2'd1);

  p_disc_off_r11: assert property (@(posedge clk) disable iff (in_reset)
    power_on && !fault_ilim && disconnect && dcon_en |=> !power_on && off_reason == 2'd2);

  p_disc_ignored_r11: assert property (@(posedge clk) disable iff (in_reset)
    power_on && !fault_ilim && !cmd_power_off && mode_eff != 2'b00 && !(disconnect && dcon_en)
    |=> power_on);

  p_host_off_r12: assert property (@(posedge clk) disable iff (in_reset)
    power_on && cmd_power_off && !fault_ilim && !(disconnect && dcon_en)
    |=> !power_on && off_reason == 2'd3);

  p_one_activity_r6: assert property (@(posedge clk) disable iff (in_reset)
    $onehot0({det_req, cls_req, power_on}));

  p_power_cause_r5: assert property (@(posedge clk) disable iff (in_reset)
    pwr_up_evt |-> ((mode_eff == 2'b01 || mode_eff == 2'b10) && cmd_power_on)
                || (mode_eff == 2'b11 && cls_req && cls_done && pol_admit));

  p_refuse_r9: assert property (@(posedge clk) disable iff (in_reset)
    mode_eff == 2'b11 && cls_req && cls_done && !pol_admit && !power_on |=> !power_on);

  p_straps_hold_r2: assert property (@(posedge clk) disable iff (in_reset)
    !$past(in_reset) |-> $stable(auto_q) && $stable(bud_q));
endmodule

bind pse_port_ctrl pse_port_ctrl_chk u_chk (
  .clk           (clk),
  .in_reset      (in_reset),
  .mode_eff      (mode_eff),
  .power_on      (power_on),
  .det_req       (det_req),
  .cls_req       (cls_req),
  .fault_ilim    (fault_ilim),
  .disconnect    (disconnect),
  .dcon_en       (dcon_en),
  .cmd_power_on  (cmd_power_on),
  .cmd_power_off (cmd_power_off),
  .cls_done      (cls_done),
  .pol_admit     (pol_admit),
  .pwr_up_evt    (pwr_up_evt),
  .auto_q        (auto_q),
  .bud_q         (bud_q),
  .off_reason    (off_reason)
);

// File: tb/pse_port_ctrl_bench.sv
module pse_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;
  localparam int ENG_LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_all = 1'b0;
  logic strap_auto = 1'b0, strap_mid = 1'b1;
  logic [1:0] strap_pwr = 2'b01;
  logic [1:0] opmode = 2'b01;
  logic det_en = 1'b0, cls_en = 1'b0, dcon_en = 1'b0;
  logic cmd_detect = 1'b0, cmd_classify = 1'b0, cmd_power_on = 1'b0, cmd_power_off = 1'b0;
  logic det_done = 1'b0, det_valid = 1'b0, cls_done = 1'b0;
  logic [2:0] cls_result = 3'd0;
  logic fault_ilim = 1'b0, disconnect = 1'b0;
  logic det_req, cls_req, power_on, det_status, midspan;
  logic [2:0] class_status;
  logic [1:0] off_reason;
  logic [9:0] icut_code, ilim_code;

  logic       resp_valid = 1'b1;
  logic [2:0] resp_class = 3'd0;

  int checks = 0, errors = 0, cyc = 0, npos = 0, dcnt = 0, ccnt = 0;
  bit done_flag = 0;

  // reference model state
  int m_st = 0, m_dok = 0, m_cls = 0, m_why = 0, m_cut = 375, m_lim = 425;
  int m_auto = 0, m_mid = 0, m_bud = 0;
  int cut_t [8] = '{375, 112, 206, 375, 638, 750, 850, 950};
  int lim_t [8] = '{425, 425, 425, 425, 850, 1000, 1000, 1023};

  pse_port_ctrl u_pse_port_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_all(reset_all),
    .strap_auto(strap_auto), .strap_mid(strap_mid), .strap_pwr(strap_pwr),
    .opmode(opmode), .det_en(det_en), .cls_en(cls_en), .dcon_en(dcon_en),
    .cmd_detect(cmd_detect), .cmd_classify(cmd_classify),
    .cmd_power_on(cmd_power_on), .cmd_power_off(cmd_power_off),
    .det_done(det_done), .det_valid(det_valid), .cls_done(cls_done),
    .cls_result(cls_result), .fault_ilim(fault_ilim), .disconnect(disconnect),
    .det_req(det_req), .cls_req(cls_req), .power_on(power_on),
    .det_status(det_status), .class_status(class_status), .off_reason(off_reason),
    .icut_code(icut_code), .ilim_code(ilim_code), .midspan(midspan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model: one update per rising edge, from the inputs held since the last falling edge
  always @(posedge clk) begin
    int eff, tier;
    bit may_on;
    npos++;
    if (!rst_n || reset_all) begin
      m_auto = strap_auto; m_mid = strap_mid; m_bud = strap_pwr;
      m_st = 0; m_dok = 0; m_cls = 0; m_why = 0; m_cut = 375; m_lim = 425;
    end else begin
      eff = (opmode == 2'b11 && m_auto == 0) ? 0 : int'(opmode);
      may_on = (eff == 1) || (eff == 2 && m_dok == 1);
      if (m_st == 3) begin
        if (fault_ilim) begin m_why = 1; m_st = 0; m_dok = 0; end
        else if (disconnect && dcon_en) begin m_why = 2; m_st = 0; m_dok = 0; end
        else if (cmd_power_off || eff == 0) begin m_why = 3; m_st = 0; m_dok = 0; end
      end else if (eff == 0) m_st = 0;
      else if (cmd_power_on && may_on) m_st = 3;
      else if (m_st == 0) begin
        if (eff == 1) m_st = cmd_detect ? 1 : (cmd_classify ? 2 : 0);
        else if (eff == 2) m_st = det_en ? 1 : 0;
        else m_st = 1;
      end else if (m_st == 1) begin
        if (det_done) begin
          m_dok = det_valid;
          m_st = (det_valid && (eff == 3 || (eff == 2 && cls_en))) ? 2 : 0;
        end
      end else if (m_st == 2) begin
        if (cls_done) begin
          m_cls = cls_result;
          tier = (cls_result < 5) ? 0 : cls_result - 4;
          if (eff == 3 && tier <= m_bud) begin
            m_st = 3; m_cut = cut_t[cls_result]; m_lim = lim_t[cls_result];
          end else m_st = 0;
        end
      end
    end
  end

  // per-cycle comparison and engine responders on the falling edge
  always @(negedge clk) begin
    if (npos > 0 && !done_flag) begin
      chk("R7",  "power_on",     16'(power_on),     16'(m_st == 3));
      chk("R6",  "det_req",      16'(det_req),      16'(m_st == 1));
      chk("R4",  "cls_req",      16'(cls_req),      16'(m_st == 2));
      chk("R4",  "det_status",   16'(det_status),   16'(m_dok));
      chk("R4",  "class_status", 16'(class_status), 16'(m_cls));
      chk("R10", "off_reason",   16'(off_reason),   16'(m_why));
      chk("R8",  "icut_code",    16'(icut_code),    16'(m_cut));
      chk("R8",  "ilim_code",    16'(ilim_code),    16'(m_lim));
      chk("R2",  "midspan",      16'(midspan),      16'(m_mid));
    end
    if (det_done) begin det_done = 1'b0; dcnt = 0; end
    else if (det_req === 1'b1) begin dcnt++; if (dcnt >= ENG_LAT) det_done = 1'b1; end
    else dcnt = 0;
    if (cls_done) begin cls_done = 1'b0; ccnt = 0; end
    else if (cls_req === 1'b1) begin ccnt++; if (ccnt >= ENG_LAT) cls_done = 1'b1; end
    else ccnt = 0;
    det_valid  = resp_valid;
    cls_result = resp_class;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    // reset with autonomous strap low, budget 01, midspan high
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R13", "reset power_on", 16'(power_on), 16'd0);
    chk("R13", "reset icut", icut_code, 16'd375);
    chk("R13", "reset ilim", ilim_code, 16'd425);
    chk("R2",  "midspan latched", 16'(midspan), 16'd1);

    // manual mode: single detection, single classification, host power
    resp_valid = 1'b1; resp_class = 3'd2;
    cmd_detect = 1'b1; step(1); cmd_detect = 1'b0;
    step(10);
    chk("R4", "manual det result", 16'(det_status), 16'd1);
    chk("R4", "manual no repeat", 16'(det_req), 16'd0);
    cmd_classify = 1'b1; step(1); cmd_classify = 1'b0;
    step(10);
    chk("R4", "manual class result", 16'(class_status), 16'd2);
    cmd_power_on = 1'b1; step(1); cmd_power_on = 1'b0;
    step(1);
    chk("R5", "manual power on", 16'(power_on), 16'd1);
    chk("R8", "manual keeps icut", icut_code, 16'd375);
    cmd_power_off = 1'b1; step(1); cmd_power_off = 1'b0;
    chk("R12", "host off", 16'(power_on), 16'd0);
    chk("R12", "host off reason", 16'(off_reason), 16'd3);
    chk("R12", "det cleared", 16'(det_status), 16'd0);

    // manual fault while powered
    cmd_power_on = 1'b1; step(1); cmd_power_on = 1'b0;
    step(2);
    fault_ilim = 1'b1; disconnect = 1'b1; dcon_en = 1'b1; step(1);
    fault_ilim = 1'b0; disconnect = 1'b0; dcon_en = 1'b0;
    chk("R10", "fault off", 16'(power_on), 16'd0);
    chk("R10", "fault outranks", 16'(off_reason), 16'd1);

    // semi-auto
    opmode = 2'b10;
    step(10);
    chk("R6", "semi no enable", 16'(det_req), 16'd0);
    cmd_power_on = 1'b1; step(1); cmd_power_on = 1'b0;
    step(1);
    chk("R5", "semi refuses without detection", 16'(power_on), 16'd0);
    resp_class = 3'd3; det_en = 1'b1; cls_en = 1'b1;
    step(40);
    chk("R6", "semi never self-powers", 16'(power_on), 16'd0);
    chk("R6", "semi classified", 16'(class_status), 16'd3);
    cmd_power_on = 1'b1; step(1); cmd_power_on = 1'b0;
    chk("R5", "semi power on", 16'(power_on), 16'd1);
    disconnect = 1'b1; step(3);
    chk("R11", "disconnect ignored", 16'(power_on), 16'd1);
    dcon_en = 1'b1; step(1);
    chk("R11", "disconnect off", 16'(power_on), 16'd0);
    chk("R11", "disconnect reason", 16'(off_reason), 16'd2);
    disconnect = 1'b0; dcon_en = 1'b0; det_en = 1'b0; cls_en = 1'b0;

    // reserved code without autonomous strap
    opmode = 2'b11;
    step(12);
    chk("R1", "reserved no detect", 16'(det_req), 16'd0);
    chk("R1", "reserved no class", 16'(cls_req), 16'd0);

    // reset with autonomous strap high and smallest budget, then move straps
    strap_auto = 1'b1; strap_pwr = 2'b00; strap_mid = 1'b0;
    rst_n = 1'b0; step(3); rst_n = 1'b1;
    strap_auto = 1'b0; strap_pwr = 2'b11; strap_mid = 1'b1;
    resp_valid = 1'b1; resp_class = 3'd4;
    step(20);
    chk("R2", "midspan held", 16'(midspan), 16'd0);
    chk("R7", "auto power up", 16'(power_on), 16'd1);
    chk("R8", "class4 icut", icut_code, 16'd638);
    chk("R8", "class4 ilim", ilim_code, 16'd850);
    resp_class = 3'd6;
    fault_ilim = 1'b1; step(1); fault_ilim = 1'b0;
    chk("R10", "auto fault off", 16'(off_reason), 16'd1);
    step(1);
    chk("R12", "auto re-detect", 16'(det_req), 16'd1);
    step(40);
    chk("R9", "class6 refused", 16'(power_on), 16'd0);
    chk("R9", "class6 recorded", 16'(class_status), 16'd6);
    chk("R8", "codes kept on refusal", icut_code, 16'd638);
    resp_valid = 1'b0;
    step(20);
    chk("R7", "invalid detection", 16'(det_status), 16'd0);

    // global reset bit recaptures straps (budget now 11)
    resp_valid = 1'b1; resp_class = 3'd7;
    strap_auto = 1'b1;
    reset_all = 1'b1; step(1); reset_all = 1'b0;
    chk("R13", "reset_all reason", 16'(off_reason), 16'd0);
    chk("R13", "reset_all icut", icut_code, 16'd375);
    step(25);
    chk("R9", "class7 admitted", 16'(power_on), 16'd1);
    chk("R8", "class7 icut", icut_code, 16'd950);
    chk("R8", "class7 ilim", ilim_code, 16'd1023);
    cmd_power_on = 1'b1; step(1); cmd_power_on = 1'b0;
    chk("R5", "auto ignores host on", 16'(power_on), 16'd1);
    opmode = 2'b00; step(1);
    chk("R3", "shutdown off", 16'(power_on), 16'd0);
    chk("R3", "shutdown reason", 16'(off_reason), 16'd3);
    step(10);
    chk("R3", "shutdown idle", 16'(det_req), 16'd0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule